// File: doc/BRIEF.md
# Saturating Wiper Position Controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. A host drives three slow control pins: an active-low select, an increment strobe and a direction level. The block moves a 5-bit wiper position by one tap on each falling edge of the strobe while it is selected. It stops at either end of the range and never wraps. The position is decoded onto a one-hot tap-select bus that would drive the analog switch network.

When select is released, the level of the strobe at that moment decides what happens. If the strobe is high, the position is committed to a modelled nonvolatile cell and a store-busy period begins. If the strobe is low, the new position stays in effect without being committed. A modelled power-cycle pulse reloads the position from the nonvolatile cell, which keeps its content across that pulse. All three control pins are brought into the system clock domain through two-flop synchronisers, so a pin change reaches the wiper at the third rising clock edge after it.

Two counters are provided for observation. One counts taps actually moved and the other counts commits.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset the position equals the parameter NV_INIT (default 16), the nonvolatile cell holds NV_INIT, both counters read 0 and store_busy is low.
- R2: tap_sel is one-hot, and its set bit index equals wiper_pos (bit i is tap i).
- R3: While selected, each high-to-low transition of inc_strobe moves the position by one tap, and a rising inc_strobe does not move it.
- R4: The position saturates: a step up at TAPS-1 and a step down at 0 leave it unchanged, and step_count counts only steps that changed the position.
- R5: Strobe edges while sel_n is high do not move the position.
- R6: up_dn may change during one selection; up_dn high steps up and low steps down.
- R7: A rising sel_n of an active selection with inc_strobe high copies the position into the nonvolatile cell, increments store_count, and holds store_busy high for STORE_CYCLES clock cycles.
- R8: A rising sel_n with inc_strobe low stores nothing: the position stays in effect and store_count is unchanged.
- R9: A pwr_cycle pulse reloads the position from the nonvolatile cell and ends any busy period, and the counters are kept.
- R10: While store_busy is high, a falling sel_n does not start a selection and strobe edges do not move the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset, including the nonvolatile cell |
| pwr_cycle | input | 1 | Synchronous one-cycle pulse modelling a power cycle |
| sel_n | input | 1 | Active-low select, asynchronous |
| inc_strobe | input | 1 | Step strobe, acts on its falling edge, asynchronous |
| up_dn | input | 1 | Direction level, 1 = up, asynchronous |
| wiper_pos | output | POS_W | Current wiper position |
| tap_sel | output | TAPS | One-hot tap select |
| store_busy | output | 1 | High during a store cycle |
| step_count | output | CNT_W | Number of taps moved |
| store_count | output | CNT_W | Number of commits to the nonvolatile cell |

## Verification
On every cycle the assertions check that the tap bus stays one-hot on the wiper position and that the position moves at most one tap and only on an accepted step. They also check that saturated steps leave the position and the step counter alone, that a busy period starts only from a commit, and that no step is accepted while busy. Only the bench scenarios can show the decision at the end of a selection. A commit later shows up through a power-cycle reload, while a discard keeps the new position until power is cycled, and a selection started during a busy period stays dead after the busy period ends.

// File: rtl/wc_pkg.sv
package wc_pkg;

  // synchronised control pins, select in the top bit
  typedef struct packed {
    logic sel_n;
    logic inc;
    logic up;
  } wc_ctl_t;

  localparam wc_ctl_t WC_CTL_IDLE = '{sel_n: 1'b1, inc: 1'b1, up: 1'b0};

  // one saturating step on a position bounded by [0, last]
  function automatic logic [15:0] wc_sat_step(input logic [15:0] cur,
                                               input logic [15:0] last,
                                               input logic        up);
    if (up) return (cur >= last) ? cur : cur + 16'd1;
    else    return (cur == 16'd0) ? cur : cur - 16'd1;
  endfunction

endpackage

// File: rtl/wc_sync.sv
module wc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/wc_wiper.sv
module wc_wiper
  import wc_pkg::*;
#(
  parameter int unsigned TAPS    = 32,
  parameter int unsigned POS_W   = 5,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NV_INIT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_ev,
  input  logic             step_up,
  input  logic             load_ev,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] pos,
  output logic [CNT_W-1:0] step_count
);
  logic [POS_W-1:0] nxt_pos;
  logic             moves;

  assign nxt_pos = POS_W'(wc_sat_step(16'(pos), 16'(TAPS - 1), step_up));
  assign moves   = step_ev && (nxt_pos != pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos        <= POS_W'(NV_INIT);
      step_count <= '0;
    end else if (load_ev) begin
      pos <= load_val;
    end else if (moves) begin
      pos        <= nxt_pos;
      step_count <= step_count + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wc_nvstore.sv
module wc_nvstore #(
  parameter int unsigned POS_W        = 5,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned NV_INIT      = 16,
  parameter int unsigned STORE_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_ev,
  input  logic             pwr_cycle,
  input  logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nv_val,
  output logic             busy,
  output logic [CNT_W-1:0] store_count
);
  localparam int unsigned TMR_W = $clog2(STORE_CYCLES + 1);

  logic [TMR_W-1:0] timer_q;

  assign busy = (timer_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_val      <= POS_W'(NV_INIT);
      timer_q     <= '0;
      store_count <= '0;
    end else if (pwr_cycle) begin
      timer_q <= '0;
    end else if (store_ev) begin
      nv_val      <= pos;
      timer_q     <= TMR_W'(STORE_CYCLES);
      store_count <= store_count + CNT_W'(1);
    end else if (busy) begin
      timer_q <= timer_q - TMR_W'(1);
    end
  end
endmodule

// File: rtl/wc_decode.sv
module wc_decode #(
  parameter int unsigned TAPS  = 32,
  parameter int unsigned POS_W = 5
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (pos == POS_W'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wc_pkg::*;
#(
  parameter int unsigned TAPS         = 32,
  parameter int unsigned NV_INIT      = 16,
  parameter int unsigned STORE_CYCLES = 250000,
  parameter int unsigned CNT_W        = 16,
  localparam int unsigned POS_W       = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_cycle,
  input  logic             sel_n,
  input  logic             inc_strobe,
  input  logic             up_dn,
  output logic [POS_W-1:0] wiper_pos,
  output logic [TAPS-1:0]  tap_sel,
  output logic             store_busy,
  output logic [CNT_W-1:0] step_count,
  output logic [CNT_W-1:0] store_count
);
  wc_ctl_t          ctl_raw, ctl_s;
  logic             sel_n_prev, inc_prev;
  logic             sel_fall, sel_rise, inc_fall;
  logic             selected_q;
  logic             step_ev, store_ev;
  logic [POS_W-1:0] nv_val;

  assign ctl_raw = '{sel_n: sel_n, inc: inc_strobe, up: up_dn};

  wc_sync #(.W(3), .RST_VAL(WC_CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_n_prev <= 1'b1;
      inc_prev   <= 1'b1;
    end else begin
      sel_n_prev <= ctl_s.sel_n;
      inc_prev   <= ctl_s.inc;
    end
  end

  assign sel_fall = sel_n_prev && !ctl_s.sel_n;
  assign sel_rise = !sel_n_prev && ctl_s.sel_n;
  assign inc_fall = inc_prev && !ctl_s.inc;

  // a selection only opens on a falling select seen outside a busy period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       selected_q <= 1'b0;
    else if (pwr_cycle || sel_rise)   selected_q <= 1'b0;
    else if (sel_fall && !store_busy) selected_q <= 1'b1;
  end

  assign step_ev  = selected_q && !ctl_s.sel_n && inc_fall && !store_busy && !pwr_cycle;
  assign store_ev = selected_q && sel_rise && ctl_s.inc && !pwr_cycle;

  wc_wiper #(.TAPS(TAPS), .POS_W(POS_W), .CNT_W(CNT_W), .NV_INIT(NV_INIT)) u_wiper (
    .clk(clk), .rst_n(rst_n), .step_ev(step_ev), .step_up(ctl_s.up),
    .load_ev(pwr_cycle), .load_val(nv_val), .pos(wiper_pos), .step_count(step_count)
  );

  wc_nvstore #(.POS_W(POS_W), .CNT_W(CNT_W), .NV_INIT(NV_INIT),
               .STORE_CYCLES(STORE_CYCLES)) u_nv (
    .clk(clk), .rst_n(rst_n), .store_ev(store_ev), .pwr_cycle(pwr_cycle),
    .pos(wiper_pos), .nv_val(nv_val), .busy(store_busy), .store_count(store_count)
  );

  wc_decode #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
    .pos(wiper_pos), .tap_sel(tap_sel)
  );
endmodule

// File: rtl/wc_checker.sv
module wc_checker #(
  parameter int unsigned TAPS  = 32,
  parameter int unsigned POS_W = 5,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_cycle,
  input logic             step_ev,
  input logic             step_up,
  input logic             store_ev,
  input logic             store_busy,
  input logic [POS_W-1:0] wiper_pos,
  input logic [TAPS-1:0]  tap_sel,
  input logic [CNT_W-1:0] step_count
);
  assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[wiper_pos]);

  assert_move_needs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pwr_cycle) && (wiper_pos != $past(wiper_pos))) |-> $past(step_ev));

  assert_single_tap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_cycle) |->
      ((int'(wiper_pos) - int'($past(wiper_pos)) <= 1) &&
       (int'($past(wiper_pos)) - int'(wiper_pos) <= 1)));

  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && step_up && !pwr_cycle && (int'(wiper_pos) == TAPS - 1))
      |=> (int'(wiper_pos) == TAPS - 1));

  assert_sat_bottom_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ev && !step_up && !pwr_cycle && (wiper_pos == '0)) |=> (wiper_pos == '0));

  assert_count_tracks_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_cycle) |->
      ((step_count != $past(step_count)) == (wiper_pos != $past(wiper_pos))));

  assert_busy_after_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    store_ev |=> store_busy);

  assert_busy_from_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_busy) |-> $past(store_ev));

  assert_no_step_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    store_busy |-> !step_ev);
endmodule

bind wiper_ctrl wc_checker #(.TAPS(TAPS), .POS_W(POS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .step_ev(step_ev),
  .step_up(ctl_s.up), .store_ev(store_ev), .store_busy(store_busy),
  .wiper_pos(wiper_pos), .tap_sel(tap_sel), .step_count(step_count)
);

// File: tb/wiper_ctrl_tb_top.sv
module wiper_ctrl_tb_top;
  localparam int TAPS  = 32;
  localparam int POS_W = 5;
  localparam int CNT_W = 16;
  localparam int INIT  = 16;
  localparam int BUSYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_cycle = 1'b0;
  logic sel_n = 1'b1;
  logic inc_strobe = 1'b1;
  logic up_dn = 1'b0;
  logic [POS_W-1:0] wiper_pos;
  logic [TAPS-1:0]  tap_sel;
  logic             store_busy;
  logic [CNT_W-1:0] step_count, store_count;

  always #10 clk = ~clk;  // 50 MHz

  wiper_ctrl #(.TAPS(TAPS), .NV_INIT(INIT), .STORE_CYCLES(BUSYC), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .sel_n(sel_n),
    .inc_strobe(inc_strobe), .up_dn(up_dn), .wiper_pos(wiper_pos), .tap_sel(tap_sel),
    .store_busy(store_busy), .step_count(step_count), .store_count(store_count)
  );

  typedef struct {
    int    pos;
    int    steps;
    int    stores;
    bit    busy;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // bench-side model
  int m_pos = INIT, m_nv = INIT, m_steps = 0, m_stores = 0;
  bit m_sel = 0, m_busy = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag);
    exp_t e;
    e.pos = m_pos; e.steps = m_steps; e.stores = m_stores; e.busy = m_busy; e.tag = tag;
    exp_q.push_back(e);
    tick(1);
  endtask

  task automatic do_select();
    sel_n = 1'b0; tick(4);
    if (!m_busy) m_sel = 1;
  endtask

  // one strobe; hold_low leaves the strobe low afterwards
  task automatic do_step(input bit up, input bit hold_low);
    up_dn = up; tick(4);
    inc_strobe = 1'b0; tick(4);
    if (m_sel && !m_busy) begin
      if (up && m_pos < TAPS - 1) begin m_pos++; m_steps++; end
      else if (!up && m_pos > 0) begin m_pos--; m_steps++; end
    end
    if (!hold_low) begin inc_strobe = 1'b1; tick(4); end
  endtask

  task automatic do_deselect();
    bit inc_lvl = inc_strobe;
    sel_n = 1'b1; tick(4);
    if (m_sel && inc_lvl) begin m_nv = m_pos; m_stores++; m_busy = 1; end
    m_sel = 0;
    if (!inc_lvl) begin inc_strobe = 1'b1; tick(4); end
  endtask

  task automatic do_power();
    pwr_cycle = 1'b1; tick(1);
    pwr_cycle = 1'b0; tick(2);
    m_pos = m_nv; m_busy = 0; m_sel = 0;
  endtask

  task automatic wait_idle();
    tick(BUSYC + 10);
    m_busy = 0;
  endtask

  // monitor: compare outputs at the moment an expectation is queued
  initial begin
    forever begin
      exp_t e;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      checks++;
      if (int'(wiper_pos) != e.pos || tap_sel != (TAPS'(1) << e.pos) ||
          int'(step_count) != e.steps || int'(store_count) != e.stores ||
          store_busy != e.busy) begin
        errors++;
        $display("FAIL %s: pos=%0d tap=%h steps=%0d stores=%0d busy=%0b, expected pos=%0d tap=%h steps=%0d stores=%0d busy=%0b",
                 e.tag, wiper_pos, tap_sel, step_count, store_count, store_busy,
                 e.pos, TAPS'(1) << e.pos, e.steps, e.stores, e.busy);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    expect_now("R1 reset state and R2 decode");

    do_step(1, 0);
    expect_now("R5 strobe while deselected");

    do_select();
    repeat (3) do_step(1, 0);
    expect_now("R3 three steps up");
    do_step(0, 0);
    expect_now("R6 direction change in one selection");

    repeat (20) do_step(1, 0);
    expect_now("R4 saturate at top");
    repeat (40) do_step(0, 0);
    expect_now("R4 saturate at bottom");
    repeat (5) do_step(1, 0);
    expect_now("R2 decode at tap 5");

    do_deselect();
    expect_now("R7 commit with strobe high");

    do_select();
    do_step(1, 0);
    expect_now("R10 step ignored while busy");
    wait_idle();
    expect_now("R7 busy period ended");
    do_step(1, 0);
    expect_now("R10 selection opened during busy stays dead");
    do_deselect();
    expect_now("R10 no commit from dead selection");

    do_select();
    do_step(1, 0);
    do_step(1, 0);
    do_step(1, 1);
    do_deselect();
    expect_now("R8 discard keeps new position");

    do_power();
    expect_now("R9 reload after discard");

    do_select();
    do_step(1, 0);
    do_deselect();
    expect_now("R7 second commit");
    do_power();
    expect_now("R9 reload ends busy and keeps counts");

    done = 1;
    tick(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule